// File: doc/BRIEF.md
# Host-Side Nonvolatile Store Programming Controller

This block lets a host reach a word-organised nonvolatile store through a small set of byte registers on the expansion bus. The registers respond only while the card sits in the Plug and Play configuration state. That state comes from outside the block on `cfg_active`. When the card is in any other state, register reads return zero and register writes change nothing.

The host sets up a transfer in three steps. It writes the low eight address bits to 0xF1. For a write, it puts the high data byte in 0xF2 and the low data byte in 0xF3. It then writes the command register 0xF0, which holds the opcode, the ninth address bit and the go-ahead bit. A command write with go-ahead set starts the operation. The status register 0x05 reports busy (bit 0 = 0) until the operation finishes. After that it reports done (bit 0 = 1), and the go-ahead bit clears itself.

A write commits the word `{0xF2,0xF3}` at the address `{A8,0xF1}` when its long busy period ends. The busy period stands in for the programming time of the store. A read loads the stored word back into 0xF2/0xF3 after a short delay. Address bit A8 = 1 selects the upper half, which holds the resource data. A8 = 0 selects the lower half, which belongs to the card. The store is modelled as a 512 x 16 synchronous RAM.

Top module: `eeprog_ctrl`

## Requirements
- R1: While `cfg_active` is 0, `bus_hit` is 0 and `bus_rdata` is 0 for every address. Register writes in that state change no register and start no operation.
- R2: Command register 0xF0 reads back as {A8 in bit 7, zeros in bits 6..3, go-ahead in bit 2, opcode in bits 1..0}. Reserved bits written as 1 read back as 0.
- R3: While idle and in the configuration state, writes to 0xF1 (address A7..A0), 0xF2 (high data byte) and 0xF3 (low data byte) read back unchanged, and `bus_hit` is 1.
- R4: A command write with go-ahead = 1 and opcode 01 (write) holds status bit 0 at 0 for exactly WRITE_CYC cycles after the write edge. After that, status bit 0 reads 1 and the go-ahead bit reads 0.
- R5: A write operation stores `{0xF2,0xF3}` at the 9-bit address `{A8,0xF1}`.
- R6: A command write with go-ahead = 1 and opcode 10 (read) is busy for exactly READ_CYC cycles. It then leaves the stored word at `{A8,0xF1}` in 0xF2 (bits 15..8) and 0xF3 (bits 7..0).
- R7: A command write with go-ahead = 1 and an invalid opcode (00 or 11), or with any reserved bit 6..3 set, is busy for exactly one cycle. It changes neither the data registers nor the store.
- R8: Writes to 0xF0..0xF3 while an operation is busy are ignored.
- R9: A command write with go-ahead = 0 stores its fields but starts no operation, so status bit 0 stays 1.
- R10: Words whose addresses differ only in A8 are independent. Writing one half leaves the same offset in the other half intact.
- R11: After reset, status bit 0 reads 1 and registers 0xF0..0xF3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_active | input | 1 | Card is in the configuration state |
| bus_addr | input | 8 | Register index |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` (combinational) |
| bus_hit | output | 1 | `bus_addr` selects a live register |

## Verification
The bench builds the block with WRITE_CYC = 40 and READ_CYC = 3 instead of a programming time of roughly 143,000 cycles. At these values the bench can count each busy window cycle by cycle and compare it with the exact figure. It can also run a run of random write/read-back pairs across both halves of the store within the cycle limit. With the short write period, the bench can also attempt register writes in the middle of an operation. Directed cases cover invalid opcodes, reserved bits, and accesses made outside the configuration state.

// File: rtl/eeprog_pkg.sv
package eeprog_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 2 * BYTE_W;
    localparam int unsigned ARR_AW = 9;

    localparam logic [7:0] OFS_CMD  = 8'hF0;
    localparam logic [7:0] OFS_ADR  = 8'hF1;
    localparam logic [7:0] OFS_DHI  = 8'hF2;
    localparam logic [7:0] OFS_DLO  = 8'hF3;
    localparam logic [7:0] OFS_STAT = 8'h05;

    typedef enum logic [1:0] {
        OPC_NONE = 2'b00,
        OPC_WR   = 2'b01,
        OPC_RD   = 2'b10,
        OPC_BAD  = 2'b11
    } opc_e;

    typedef struct packed {
        logic a8;
        logic go;
        opc_e opc;
    } cmd_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CMD,
        SEL_ADR,
        SEL_DHI,
        SEL_DLO,
        SEL_STAT
    } sel_e;

    function automatic sel_e reg_decode(input logic [7:0] a);
        sel_e s;
        case (a)
            OFS_CMD:  s = SEL_CMD;
            OFS_ADR:  s = SEL_ADR;
            OFS_DHI:  s = SEL_DHI;
            OFS_DLO:  s = SEL_DLO;
            OFS_STAT: s = SEL_STAT;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic opc_ok(input opc_e o);
        return (o == OPC_WR) || (o == OPC_RD);
    endfunction

    function automatic logic [BYTE_W-1:0] cmd_pack(input cmd_t c);
        return {c.a8, 4'b0000, c.go, c.opc};
    endfunction

endpackage

// File: rtl/eeprog_store.sv
module eeprog_store #(
    parameter int unsigned AW = 9,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rd_q <= mem[addr];
    end

    assign rdata = rd_q;

endmodule

// File: rtl/eeprog_seq.sv
module eeprog_seq
    import eeprog_pkg::*;
#(
    parameter int unsigned WRITE_CYC = 143180,
    parameter int unsigned READ_CYC  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  opc_e start_opc,
    input  logic start_bad,
    output logic busy,
    output logic done,
    output logic do_rd,
    output logic do_wr
);
    localparam int unsigned CNT_W   = $clog2(WRITE_CYC + 1);
    localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WRITE_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(READ_CYC - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    opc_e             opc_q;
    logic             eff_ok;
    logic [CNT_W-1:0] span;

    always_comb begin
        eff_ok = opc_ok(start_opc) && !start_bad;
        if (!eff_ok) begin
            span = '0;
        end else if (start_opc == OPC_WR) begin
            span = WR_LAST;
        end else begin
            span = RD_LAST;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            opc_q  <= OPC_NONE;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= span;
            opc_q  <= eff_ok ? start_opc : OPC_NONE;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy  = busy_q;
    assign done  = busy_q && (cnt_q == '0);
    assign do_rd = done && (opc_q == OPC_RD);
    assign do_wr = done && (opc_q == OPC_WR);

    // R4: busy does not drop while the timer still runs
    a_r4_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != '0) |=> busy_q);

    // R7: a rejected command finishes in the very next cycle
    a_r7_bad_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_q && !eff_ok) |=> (done && !do_rd && !do_wr));

    // R8: the register side never requests a start while busy
    a_r8_no_start_busy: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);

endmodule

// File: rtl/eeprog_regs.sv
module eeprog_regs
    import eeprog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_active,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_word,
    output logic [ARR_AW-1:0] word_addr,
    output logic [WORD_W-1:0] wr_word,
    output logic              start,
    output opc_e              start_opc,
    output logic              start_bad,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              bus_hit
);
    sel_e              sel;
    logic              wr_ok;
    cmd_t              cmd_q;
    logic [BYTE_W-1:0] adr_q;
    logic [BYTE_W-1:0] dhi_q;
    logic [BYTE_W-1:0] dlo_q;

    assign sel   = reg_decode(bus_addr);
    assign wr_ok = bus_wr && cfg_active && !busy;

    assign start     = wr_ok && (sel == SEL_CMD) && bus_wdata[2];
    assign start_opc = opc_e'(bus_wdata[1:0]);
    assign start_bad = |bus_wdata[6:3];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '{a8: 1'b0, go: 1'b0, opc: OPC_NONE};
            adr_q <= '0;
            dhi_q <= '0;
            dlo_q <= '0;
        end else begin
            if (wr_ok) begin
                case (sel)
                    SEL_CMD: cmd_q <= '{a8: bus_wdata[7], go: bus_wdata[2],
                                        opc: opc_e'(bus_wdata[1:0])};
                    SEL_ADR: adr_q <= bus_wdata;
                    SEL_DHI: dhi_q <= bus_wdata;
                    SEL_DLO: dlo_q <= bus_wdata;
                    default: ;
                endcase
            end
            if (done) begin
                cmd_q.go <= 1'b0;
            end
            if (load_en) begin
                dhi_q <= load_word[WORD_W-1:BYTE_W];
                dlo_q <= load_word[BYTE_W-1:0];
            end
        end
    end

    assign word_addr = {cmd_q.a8, adr_q};
    assign wr_word   = {dhi_q, dlo_q};

    always_comb begin
        bus_rdata = '0;
        bus_hit   = 1'b0;
        if (cfg_active) begin
            bus_hit = (sel != SEL_NONE);
            case (sel)
                SEL_CMD:  bus_rdata = cmd_pack(cmd_q);
                SEL_ADR:  bus_rdata = adr_q;
                SEL_DHI:  bus_rdata = dhi_q;
                SEL_DLO:  bus_rdata = dlo_q;
                SEL_STAT: bus_rdata = {{(BYTE_W-1){1'b0}}, !busy};
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R8: address and command fields frozen while an operation runs
    a_r8_frozen_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> ($stable(word_addr) && $stable(cmd_q.opc)));

    // R4: go-ahead clears once the operation finishes
    a_r4_go_clears: assert property (@(posedge clk) disable iff (rst)
        done |=> !cmd_q.go);

    // R1: outside configuration the host-visible registers stay put
    a_r1_cfg_gate: assert property (@(posedge clk) disable iff (rst)
        (!cfg_active && !load_en) |=> ($stable(word_addr) && $stable(wr_word)));

    // R1: nothing answers outside configuration
    a_r1_no_hit: assert property (@(posedge clk) disable iff (rst)
        !cfg_active |-> (!bus_hit && bus_rdata == '0));

endmodule

// File: rtl/eeprog_ctrl.sv
module eeprog_ctrl
    import eeprog_pkg::*;
#(
    parameter int unsigned WRITE_CYC = 143180,
    parameter int unsigned READ_CYC  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_active,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       bus_hit
);
    logic              busy;
    logic              done;
    logic              do_rd;
    logic              do_wr;
    logic              start;
    opc_e              start_opc;
    logic              start_bad;
    logic [ARR_AW-1:0] word_addr;
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] st_rdata;

    eeprog_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_active(cfg_active),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .done      (done),
        .load_en   (do_rd),
        .load_word (st_rdata),
        .word_addr (word_addr),
        .wr_word   (wr_word),
        .start     (start),
        .start_opc (start_opc),
        .start_bad (start_bad),
        .bus_rdata (bus_rdata),
        .bus_hit   (bus_hit)
    );

    eeprog_seq #(
        .WRITE_CYC(WRITE_CYC),
        .READ_CYC (READ_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .start_opc(start_opc),
        .start_bad(start_bad),
        .busy     (busy),
        .done     (done),
        .do_rd    (do_rd),
        .do_wr    (do_wr)
    );

    eeprog_store #(
        .AW(ARR_AW),
        .DW(WORD_W)
    ) u_store (
        .clk  (clk),
        .we   (do_wr),
        .addr (word_addr),
        .wdata(wr_word),
        .rdata(st_rdata)
    );

    // R5: the store word and address are stable over the cycle before commit
    a_r5_commit_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(wr_word));

endmodule

// File: tb/tb_eeprog_ctrl.sv
`timescale 1ns/1ps
module tb_eeprog_ctrl;
    localparam int unsigned WCYC = 40;
    localparam int unsigned RCYC = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_active = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       bus_hit;

    int checks = 0;
    int errors = 0;
    int wd = 0;
    logic [15:0] mdl [512];

    eeprog_ctrl #(.WRITE_CYC(WCYC), .READ_CYC(RCYC)) dut (
        .clk(clk), .rst(rst), .cfg_active(cfg_active), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_hit(bus_hit)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected<150000", wd);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [7:0] a, output logic [7:0] d, output logic h);
        bus_addr = a;
        #1;
        d = bus_rdata;
        h = bus_hit;
    endtask

    task automatic busy_len(output int n);
        logic [7:0] d;
        logic h;
        n = 0;
        forever begin
            brd(8'h05, d, h);
            if (d[0]) break;
            n = n + 1;
            @(negedge clk);
        end
    endtask

    function automatic logic [7:0] cmd_byte(input logic a8, input logic go, input logic [1:0] op);
        return {a8, 4'b0000, go, op};
    endfunction

    task automatic op_write(input logic [8:0] a, input logic [15:0] w, output int n);
        bwr(8'hF1, a[7:0]);
        bwr(8'hF2, w[15:8]);
        bwr(8'hF3, w[7:0]);
        bwr(8'hF0, cmd_byte(a[8], 1'b1, 2'b01));
        busy_len(n);
        mdl[a] = w;
    endtask

    task automatic op_read(input logic [8:0] a, output logic [15:0] w, output int n);
        logic [7:0] d;
        logic h;
        bwr(8'hF1, a[7:0]);
        bwr(8'hF0, cmd_byte(a[8], 1'b1, 2'b10));
        busy_len(n);
        brd(8'hF2, d, h); w[15:8] = d;
        brd(8'hF3, d, h); w[7:0] = d;
    endtask

    initial begin
        logic [7:0]  d;
        logic        h;
        int          n;
        logic [15:0] w;
        logic [8:0]  ra [16];
        void'($urandom(32'h5EED));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        cfg_active = 1'b1;

        // R11 reset state
        brd(8'h05, d, h); chk("R11 status", d, 8'h01);
        brd(8'hF0, d, h); chk("R11 cmd", d, 0);
        brd(8'hF1, d, h); chk("R11 adr", d, 0);
        brd(8'hF2, d, h); chk("R11 dhi", d, 0);
        brd(8'hF3, d, h); chk("R11 dlo", d, 0);

        // R3 plain register access
        bwr(8'hF1, 8'hA5); bwr(8'hF2, 8'h3C); bwr(8'hF3, 8'hC3);
        brd(8'hF1, d, h); chk("R3 adr", d, 8'hA5); chk("R3 hit", h, 1);
        brd(8'hF2, d, h); chk("R3 dhi", d, 8'h3C);
        brd(8'hF3, d, h); chk("R3 dlo", d, 8'hC3);

        // R2 reserved bits read zero; R9 go=0 starts nothing
        bwr(8'hF0, 8'hF9);
        brd(8'hF0, d, h); chk("R2 cmd readback", d, 8'h81);
        brd(8'h05, d, h); chk("R9 no start", d, 8'h01);

        // R4 R5 write operation
        op_write(9'h112, 16'hBEEF, n);
        chk("R4 write busy cycles", n, WCYC);
        brd(8'hF0, d, h); chk("R4 go cleared", d, 8'h81);

        // R6 read operation
        bwr(8'hF2, 8'h00); bwr(8'hF3, 8'h00);
        op_read(9'h112, w, n);
        chk("R6 read busy cycles", n, RCYC);
        chk("R5 R6 read data", w, 16'hBEEF);

        // R10 halves independent
        op_write(9'h012, 16'h1234, n);
        op_read(9'h112, w, n); chk("R10 upper intact", w, 16'hBEEF);
        op_read(9'h012, w, n); chk("R10 lower word", w, 16'h1234);

        // R7 invalid opcodes and reserved bits
        bwr(8'hF1, 8'h12); bwr(8'hF2, 8'h55); bwr(8'hF3, 8'hAA);
        bwr(8'hF0, cmd_byte(1'b1, 1'b1, 2'b11));
        busy_len(n); chk("R7 op11 busy", n, 1);
        bwr(8'hF0, cmd_byte(1'b1, 1'b1, 2'b00));
        busy_len(n); chk("R7 op00 busy", n, 1);
        bwr(8'hF0, 8'h8D);
        busy_len(n); chk("R7 reserved busy", n, 1);
        brd(8'hF2, d, h); chk("R7 dhi kept", d, 8'h55);
        brd(8'hF3, d, h); chk("R7 dlo kept", d, 8'hAA);
        op_read(9'h112, w, n); chk("R7 store kept", w, 16'hBEEF);

        // R8 writes during busy ignored
        bwr(8'hF1, 8'h40); bwr(8'hF2, 8'h11); bwr(8'hF3, 8'h22);
        bwr(8'hF0, cmd_byte(1'b0, 1'b1, 2'b01));
        bwr(8'hF1, 8'h41);
        bwr(8'hF2, 8'h99);
        bwr(8'hF0, cmd_byte(1'b1, 1'b1, 2'b10));
        brd(8'hF1, d, h); chk("R8 adr held", d, 8'h40);
        brd(8'hF2, d, h); chk("R8 dhi held", d, 8'h11);
        brd(8'hF0, d, h); chk("R8 cmd held", d, 8'h05);
        busy_len(n);
        mdl[9'h040] = 16'h1122;
        op_read(9'h040, w, n); chk("R8 word written", w, 16'h1122);
        op_read(9'h041, w, n);

        // R1 outside configuration
        bwr(8'hF1, 8'h33);
        cfg_active = 1'b0;
        brd(8'hF1, d, h); chk("R1 rdata zero", d, 0); chk("R1 hit low", h, 0);
        brd(8'h05, d, h); chk("R1 status zero", d, 0);
        bwr(8'hF1, 8'h77);
        bwr(8'hF0, cmd_byte(1'b0, 1'b1, 2'b01));
        repeat (2) @(negedge clk);
        cfg_active = 1'b1;
        brd(8'hF1, d, h); chk("R1 adr unchanged", d, 8'h33);
        brd(8'h05, d, h); chk("R1 no start", d, 8'h01);

        // random write/read-back pairs (R5 R10)
        for (int i = 0; i < 16; i++) begin
            ra[i] = 9'($urandom % 512);
            op_write(ra[i], 16'($urandom), n);
            chk("R4 random busy", n, WCYC);
        end
        for (int i = 0; i < 16; i++) begin
            op_read(ra[i], w, n);
            chk("R5 random readback", w, mdl[ra[i]]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule